// File: doc/BRIEF.md
# Runtime-Configurable Dual-Clock FIFO with Scaled Threshold Flags

This block is a first-in first-out queue whose write side and read side run on two unrelated clocks. Its storage is a fixed 4608-bit array. A three-bit shape code, read at run time, splits that array into one of six word-width and word-count pairings, from one-bit words 4096 deep up to 36-bit words 128 deep. Write and read positions are kept as binary counters in their own domains. They are exchanged as Gray code through two-flop synchronisers, so each side works out its own occupancy.

The write side reports full and almost-full. The read side reports empty and almost-empty. Each almost threshold is an eight-bit level multiplied by a step of one 256th of the configured word count, so the same level sets the same fraction of the queue in every shape. A clear input empties the queue from both sides at once. A pipelined read option delays read data by one more read-clock cycle and leaves the flags as they are. The shape code and the pipelined option are meant to change only while clear or reset is held.

Top module: `cfg_width_fifo`

## Requirements
- R1: While reset is held and once it is released, empty and aempty read 1, full and afull read 0, and rd_data reads 0.
- R2: Words leave in the order they were written, with the two clocks at unrelated rates. Each pointer code that crosses between the domains changes in at most one bit per clock of its own domain.
- R3: width_code 0,1,2,3,4,5 gives word widths 1,2,4,9,18,36 and depths 4096,2048,1024,512,256,128. Only the low word-width bits of wr_data are stored, and rd_data bits above the word width read 0.
- R4: full reads 1 exactly when the write-side occupancy equals the configured depth.
- R5: A write while full and a read while empty are ignored. Stored words and later read order are unchanged, and a read while empty leaves rd_data and empty unchanged.
- R6: afull reads 1 when the write-side occupancy is at least af_level times depth/256, with any fraction dropped. For example, level 20 at depth 128 gives 10, and level 1 at depth 4096 gives 16.
- R7: aempty reads 1 when the read-side occupancy is at most ae_level times depth/256, with any fraction dropped. For example, level 8 at depth 128 gives 4, and level 1 at depth 4096 gives 16.
- R8: A pulse on clr discards all stored words. Afterwards empty and aempty read 1 (with a nonzero almost-empty threshold), full and afull read 0, and rd_data reads 0.
- R9: With pipe_mode 0, rd_data takes the new word on the read-clock edge that accepts the read. It holds its value until the next accepted read.
- R10: With pipe_mode 1, rd_data takes the new word one read-clock edge later than with pipe_mode 0. empty still changes on the accepting edge.
- R11: width_code 6 and 7 behave as code 5 (36-bit words, depth 128).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| clr | input | 1 | Active-high clear; empties the queue |
| width_code | input | 3 | Shape code selecting word width and depth |
| af_level | input | 8 | Almost-full level, in steps of depth/256 |
| ae_level | input | 8 | Almost-empty level, in steps of depth/256 |
| pipe_mode | input | 1 | 1 adds one read-clock cycle of read-data latency |
| wr_en | input | 1 | Write request, write clock domain |
| wr_data | input | 36 | Write word; only the low word-width bits are kept |
| full | output | 1 | Queue holds depth words (write domain) |
| afull | output | 1 | Occupancy at or above the almost-full threshold |
| rd_en | input | 1 | Read request, read clock domain |
| rd_data | output | 36 | Read word, zero above the word width |
| empty | output | 1 | Queue holds no words (read domain) |
| aempty | output | 1 | Occupancy at or below the almost-empty threshold |

## Verification
Some properties are checked on every clock by the bound checker: a write refused while full and a read refused while empty leave their pointers where they were, each Gray-coded pointer changes in at most one bit per edge, full always comes with afull, empty always comes with aempty, and in normal read mode rd_data stays put between accepted reads. Other behaviour only shows in the bench's scenarios: the stored contents and their order in every shape code, the masking of unused bits, the exact occupancy at which each scaled threshold trips, the one-cycle shift of pipelined data, and the loss of everything on a clear.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

    localparam int unsigned LOG_DEPTH = 12;
    localparam int unsigned PTR_W     = LOG_DEPTH + 1;
    localparam int unsigned IDX_W     = LOG_DEPTH;
    localparam int unsigned ROW_W     = 36;
    localparam int unsigned LOG_ROWS  = 7;
    localparam int unsigned ROWS      = 1 << LOG_ROWS;
    localparam int unsigned LVL_W     = 8;
    localparam int unsigned OFF_W     = 6;

    typedef logic [PTR_W-1:0] ptr_t;
    typedef logic [ROW_W-1:0] row_t;

    typedef enum logic [2:0] {
        GEOM_1X4096  = 3'd0,
        GEOM_2X2048  = 3'd1,
        GEOM_4X1024  = 3'd2,
        GEOM_9X512   = 3'd3,
        GEOM_18X256  = 3'd4,
        GEOM_36X128  = 3'd5
    } geom_e;

    function automatic geom_e decode_geom(input logic [2:0] code);
        geom_e g;
        if (code > 3'd5) g = GEOM_36X128;
        else             g = geom_e'(code);
        return g;
    endfunction

    function automatic logic [OFF_W-1:0] lane_width(input geom_e g);
        logic [OFF_W-1:0] w;
        unique case (g)
            GEOM_1X4096: w = 6'd1;
            GEOM_2X2048: w = 6'd2;
            GEOM_4X1024: w = 6'd4;
            GEOM_9X512:  w = 6'd9;
            GEOM_18X256: w = 6'd18;
            default:     w = 6'd36;
        endcase
        return w;
    endfunction

    // log2 of the number of words sharing one storage row
    function automatic logic [2:0] lane_shift(input geom_e g);
        return 3'd5 - 3'(g);
    endfunction

    function automatic ptr_t geom_depth(input geom_e g);
        return ptr_t'(13'h1000 >> 3'(g));
    endfunction

    function automatic row_t width_mask(input geom_e g);
        logic [ROW_W:0] m;
        m = (37'd1 << lane_width(g)) - 37'd1;
        return m[ROW_W-1:0];
    endfunction

    // level * depth / 256, fraction dropped
    function automatic ptr_t scale_level(input logic [LVL_W-1:0] lvl, input geom_e g);
        ptr_t s;
        if (g == GEOM_36X128) s = ptr_t'(lvl >> 1);
        else                  s = ptr_t'(lvl) << (3'd4 - 3'(g));
        return s;
    endfunction

    function automatic logic [LOG_ROWS-1:0] idx_row(input logic [IDX_W-1:0] idx,
                                                    input geom_e g);
        logic [IDX_W-1:0] r;
        r = idx >> lane_shift(g);
        return r[LOG_ROWS-1:0];
    endfunction

    function automatic logic [OFF_W-1:0] idx_off(input logic [IDX_W-1:0] idx,
                                                input geom_e g);
        logic [IDX_W-1:0] lane;
        logic [OFF_W-1:0] lane6;
        lane  = idx & ((12'd1 << lane_shift(g)) - 12'd1);
        lane6 = {1'b0, lane[4:0]};
        return lane6 * lane_width(g);
    endfunction

    function automatic ptr_t bin2gray(input ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t gray2bin(input ptr_t g);
        ptr_t b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/cwf_rst_bridge.sv
module cwf_rst_bridge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);

    logic [STAGES-1:0] shreg;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) shreg <= '0;
        else         shreg <= {shreg[STAGES-2:0], 1'b1};
    end

    assign srst_n = shreg[STAGES-1];

endmodule

// File: rtl/cwf_sync.sv
module cwf_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage [STAGES];

    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
        if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[gi] <= '0;
                else        stage[gi] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[gi] <= '0;
                else        stage[gi] <= stage[gi-1];
            end
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/cwf_store.sv
module cwf_store
    import cwf_pkg::*;
(
    input  logic             wclk,
    input  logic             we,
    input  geom_e            wgeom,
    input  logic [IDX_W-1:0] widx,
    input  row_t             wdata,
    input  logic             rclk,
    input  logic             rrst_n,
    input  logic             re,
    input  geom_e            rgeom,
    input  logic [IDX_W-1:0] ridx,
    input  logic             pipe_en,
    output row_t             rdata
);

    row_t                mem [ROWS];
    logic [LOG_ROWS-1:0] wrow, rrow;
    logic [OFF_W-1:0]    woff, roff;
    row_t                wlmask, rlmask, wmask, wfield;
    row_t                rd_q, rd_p;

    // words are packed side by side inside a 36-bit row
    always_comb begin
        wrow   = idx_row(widx, wgeom);
        woff   = idx_off(widx, wgeom);
        wlmask = width_mask(wgeom);
        wmask  = wlmask << woff;
        wfield = (wdata & wlmask) << woff;
        rrow   = idx_row(ridx, rgeom);
        roff   = idx_off(ridx, rgeom);
        rlmask = width_mask(rgeom);
    end

    always_ff @(posedge wclk) begin
        if (we) mem[wrow] <= (mem[wrow] & ~wmask) | wfield;
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            rd_q <= '0;
            rd_p <= '0;
        end else begin
            if (re) rd_q <= (mem[rrow] >> roff) & rlmask;
            rd_p <= rd_q;
        end
    end

    assign rdata = pipe_en ? rd_p : rd_q;

endmodule

// File: rtl/cfg_width_fifo.sv
module cfg_width_fifo
    import cwf_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [2:0]       width_code,
    input  logic [LVL_W-1:0] af_level,
    input  logic [LVL_W-1:0] ae_level,
    input  logic             pipe_mode,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_data,
    output logic             full,
    output logic             afull,
    input  logic             rd_en,
    output logic [ROW_W-1:0] rd_data,
    output logic             empty,
    output logic             aempty
);

    logic arst_n, wsrst_n, rsrst_n;
    assign arst_n = rst_n & ~clr;

    cwf_rst_bridge #(.STAGES(SYNC_STAGES)) u_wrst (
        .clk(wclk), .arst_n(arst_n), .srst_n(wsrst_n)
    );
    cwf_rst_bridge #(.STAGES(SYNC_STAGES)) u_rrst (
        .clk(rclk), .arst_n(arst_n), .srst_n(rsrst_n)
    );

    geom_e            geom;
    ptr_t             depth, af_thr, ae_thr;
    logic [IDX_W-1:0] idx_mask;

    always_comb begin
        geom     = decode_geom(width_code);
        depth    = geom_depth(geom);
        af_thr   = scale_level(af_level, geom);
        ae_thr   = scale_level(ae_level, geom);
        idx_mask = IDX_W'(depth - ptr_t'(1));
    end

    // ---------------- write domain ----------------
    ptr_t wbin, wgray, wbin_nxt, rgray_w, rbin_w, wocc;
    logic wr_ok;

    always_comb begin
        wr_ok    = wr_en && !full;
        wbin_nxt = wbin + ptr_t'(wr_ok);
    end

    always_ff @(posedge wclk or negedge wsrst_n) begin
        if (!wsrst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nxt;
            wgray <= bin2gray(wbin_nxt);
        end
    end

    // ---------------- read domain ----------------
    ptr_t rbin, rgray, rbin_nxt, wgray_r, wbin_r, rocc;
    logic rd_ok;

    always_comb begin
        rd_ok    = rd_en && !empty;
        rbin_nxt = rbin + ptr_t'(rd_ok);
    end

    always_ff @(posedge rclk or negedge rsrst_n) begin
        if (!rsrst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_nxt;
            rgray <= bin2gray(rbin_nxt);
        end
    end

    // ---------------- crossings ----------------
    cwf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wclk), .rst_n(wsrst_n), .d(rgray), .q(rgray_w)
    );
    cwf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rclk), .rst_n(rsrst_n), .d(wgray), .q(wgray_r)
    );

    // ---------------- flags ----------------
    always_comb begin
        rbin_w = gray2bin(rgray_w);
        wocc   = wbin - rbin_w;
        full   = (wocc == depth);
        afull  = (wocc >= af_thr);
        wbin_r = gray2bin(wgray_r);
        rocc   = wbin_r - rbin;
        empty  = (rocc == '0);
        aempty = (rocc <= ae_thr);
    end

    // ---------------- storage ----------------
    cwf_store u_store (
        .wclk    (wclk),
        .we      (wr_ok),
        .wgeom   (geom),
        .widx    (wbin[IDX_W-1:0] & idx_mask),
        .wdata   (wr_data),
        .rclk    (rclk),
        .rrst_n  (rsrst_n),
        .re      (rd_ok),
        .rgeom   (geom),
        .ridx    (rbin[IDX_W-1:0] & idx_mask),
        .pipe_en (pipe_mode),
        .rdata   (rd_data)
    );

endmodule

// File: rtl/cwf_chk.sv
module cwf_chk
    import cwf_pkg::*;
(
    input logic             wclk,
    input logic             rclk,
    input logic             wrst_n,
    input logic             rrst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             full,
    input logic             afull,
    input logic             empty,
    input logic             aempty,
    input logic             pipe_mode,
    input logic [ROW_W-1:0] rd_data,
    input ptr_t             wbin,
    input ptr_t             rbin,
    input ptr_t             wgray,
    input ptr_t             rgray
);

    AST_WR_HELD_WHEN_FULL: assert property (@(posedge wclk) disable iff (!wrst_n)
        (full && wr_en) |=> $stable(wbin));  // R5

    AST_RD_HELD_WHEN_EMPTY: assert property (@(posedge rclk) disable iff (!rrst_n)
        (empty && rd_en) |=> $stable(rbin));  // R5

    AST_WGRAY_ONE_BIT: assert property (@(posedge wclk) disable iff (!wrst_n)
        1'b1 |=> $onehot0(wgray ^ $past(wgray)));  // R2

    AST_RGRAY_ONE_BIT: assert property (@(posedge rclk) disable iff (!rrst_n)
        1'b1 |=> $onehot0(rgray ^ $past(rgray)));  // R2

    AST_FULL_HAS_AFULL: assert property (@(posedge wclk) disable iff (!wrst_n)
        full |-> afull);  // R6

    AST_EMPTY_HAS_AEMPTY: assert property (@(posedge rclk) disable iff (!rrst_n)
        empty |-> aempty);  // R7

    AST_RD_DATA_HOLD: assert property (@(posedge rclk) disable iff (!rrst_n)
        (!pipe_mode && !(rd_en && !empty)) |=> $stable(rd_data));  // R9

endmodule

bind cfg_width_fifo cwf_chk u_chk (
    .wclk      (wclk),
    .rclk      (rclk),
    .wrst_n    (wsrst_n),
    .rrst_n    (rsrst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .full      (full),
    .afull     (afull),
    .empty     (empty),
    .aempty    (aempty),
    .pipe_mode (pipe_mode),
    .rd_data   (rd_data),
    .wbin      (wbin),
    .rbin      (rbin),
    .wgray     (wgray),
    .rgray     (rgray)
);

// File: tb/cfg_width_fifo_tb.sv
module cfg_width_fifo_tb;

    localparam int CLK_PERIOD  = 10;
    localparam int RCLK_PERIOD = 14;

    logic        wclk = 1'b0, rclk = 1'b0;
    logic        rst_n = 1'b0, clr = 1'b0;
    logic [2:0]  width_code = 3'd3;
    logic [7:0]  af_level = 8'd200, ae_level = 8'd0;
    logic        pipe_mode = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [35:0] wr_data = '0;
    logic        full, afull, empty, aempty;
    logic [35:0] rd_data;

    cfg_width_fifo u_dut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .clr(clr),
        .width_code(width_code), .af_level(af_level), .ae_level(ae_level),
        .pipe_mode(pipe_mode), .wr_en(wr_en), .wr_data(wr_data),
        .full(full), .afull(afull), .rd_en(rd_en), .rd_data(rd_data),
        .empty(empty), .aempty(aempty)
    );

    always #(CLK_PERIOD/2)  wclk = ~wclk;
    always #(RCLK_PERIOD/2) rclk = ~rclk;

    int          checks = 0, errors = 0;
    bit          finished = 1'b0;
    logic [35:0] exp_q [$];
    logic [35:0] last_rd = '0;
    string       cur_req = "R2";
    event        rd_issued;

    function automatic logic [35:0] mask_for(input logic [2:0] c);
        case (c)
            3'd0:    return 36'h1;
            3'd1:    return 36'h3;
            3'd2:    return 36'hF;
            3'd3:    return 36'h1FF;
            3'd4:    return 36'h3FFFF;
            default: return 36'hF_FFFF_FFFF;
        endcase
    endfunction

    function automatic logic [35:0] pat(input int i);
        return 36'h9_6A5C_3E1F ^ (36'(i) * 36'h0_0D1B_4E9D);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic settle();
        #(RCLK_PERIOD * 10);
    endtask

    // driver: pushes expected words into the scoreboard
    task automatic do_write(input logic [35:0] d);
        @(negedge wclk);
        wr_en   = 1'b1;
        wr_data = d;
        if (!full) exp_q.push_back(d & mask_for(width_code));
        @(negedge wclk);
        wr_en = 1'b0;
    endtask

    task automatic do_read();
        @(negedge rclk);
        rd_en = 1'b1;
        if (!empty) -> rd_issued;
        @(negedge rclk);
        rd_en = 1'b0;
        repeat (2) @(negedge rclk);
    endtask

    task automatic do_clear(input logic [2:0] code, input logic pipe);
        @(negedge wclk);
        clr = 1'b1;
        width_code = code;
        pipe_mode  = pipe;
        repeat (3) @(negedge wclk);
        clr = 1'b0;
        exp_q.delete();
        last_rd = '0;
        settle();
    endtask

    // monitor: pops the scoreboard as read words come out
    initial begin
        forever begin
            logic [35:0] exp;
            @(rd_issued);
            if (exp_q.size() == 0) begin
                check(1'b0, cur_req, "read with empty scoreboard", rd_data, '0);
                exp = rd_data;
            end else begin
                exp = exp_q.pop_front();
            end
            if (pipe_mode) begin
                @(negedge rclk);
                check(rd_data === last_rd, "R10", "pipelined data still old one edge after read", rd_data, last_rd);
                @(negedge rclk);
                check(rd_data === exp, "R10", "pipelined read word", rd_data, exp);
            end else begin
                @(negedge rclk);
                check(rd_data === exp, cur_req, "read word on accepting edge", rd_data, exp);
            end
            last_rd = exp;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge wclk);
        // R1: state while reset held
        check(empty === 1'b1 && full === 1'b0, "R1", "flags during reset", {34'b0, empty, full}, 36'h2);
        rst_n = 1'b1;
        settle();
        check(empty === 1'b1, "R1", "empty after reset", 36'(empty), 36'h1);
        check(aempty === 1'b1, "R1", "aempty after reset", 36'(aempty), 36'h1);
        check(full === 1'b0, "R1", "full after reset", 36'(full), 36'h0);
        check(afull === 1'b0, "R1", "afull after reset", 36'(afull), 36'h0);
        check(rd_data === '0, "R1", "rd_data after reset", rd_data, '0);

        // R2: order with 9-bit words
        cur_req = "R2";
        for (int i = 0; i < 6; i++) do_write(pat(i));
        settle();
        for (int i = 0; i < 6; i++) do_read();

        // R3: every shape code
        cur_req = "R3";
        for (int c = 0; c < 6; c++) begin
            do_clear(3'(c), 1'b0);
            for (int i = 0; i < 4; i++) do_write(pat(10 * c + i) | 36'hF_0000_0000);
            settle();
            for (int i = 0; i < 4; i++) do_read();
            check((rd_data & ~mask_for(3'(c))) === '0, "R3", "upper bits zero", rd_data, rd_data & mask_for(3'(c)));
        end

        // R4 / R5: fill 36x128 and push past the top
        af_level = 8'd200;
        do_clear(3'd5, 1'b0);
        for (int i = 0; i < 127; i++) do_write(pat(100 + i));
        check(full === 1'b0, "R4", "not full at depth-1", 36'(full), 36'h0);
        do_write(pat(227));
        check(full === 1'b1, "R4", "full at depth", 36'(full), 36'h1);
        do_write(36'hB_ADBA_DBAD);
        do_write(36'hD_EADB_EEF0);
        check(full === 1'b1, "R5", "full after ignored writes", 36'(full), 36'h1);
        settle();
        cur_req = "R5";
        for (int i = 0; i < 128; i++) do_read();
        settle();
        check(empty === 1'b1, "R5", "empty after draining", 36'(empty), 36'h1);
        do_read();
        check(rd_data === last_rd, "R5", "read while empty leaves rd_data", rd_data, last_rd);
        check(empty === 1'b1, "R5", "read while empty leaves empty", 36'(empty), 36'h1);
        do_write(36'h1_2345_6789);
        settle();
        do_read();

        // R6 / R7: thresholds at depth 128
        af_level = 8'd20;
        ae_level = 8'd8;
        do_clear(3'd5, 1'b0);
        for (int i = 0; i < 9; i++) do_write(pat(300 + i));
        check(afull === 1'b0, "R6", "afull below 10", 36'(afull), 36'h0);
        do_write(pat(309));
        check(afull === 1'b1, "R6", "afull at 10", 36'(afull), 36'h1);
        settle();
        check(aempty === 1'b0, "R7", "aempty clear at 10", 36'(aempty), 36'h0);
        cur_req = "R7";
        for (int i = 0; i < 5; i++) do_read();
        check(aempty === 1'b0, "R7", "aempty clear at 5", 36'(aempty), 36'h0);
        do_read();
        check(aempty === 1'b1, "R7", "aempty at 4", 36'(aempty), 36'h1);

        // R8: clear discards the remaining words
        cur_req = "R8";
        for (int i = 0; i < 3; i++) do_write(pat(400 + i));
        do_clear(3'd5, 1'b0);
        check(empty === 1'b1 && aempty === 1'b1, "R8", "empty/aempty after clear", {34'b0, empty, aempty}, 36'h3);
        check(full === 1'b0 && afull === 1'b0, "R8", "full/afull after clear", {34'b0, full, afull}, 36'h0);
        check(rd_data === '0, "R8", "rd_data after clear", rd_data, '0);
        do_write(36'h0_0000_005A);
        settle();
        do_read();

        // R6 / R7 scaling at depth 4096
        af_level = 8'd1;
        ae_level = 8'd1;
        do_clear(3'd0, 1'b0);
        for (int i = 0; i < 15; i++) do_write(pat(500 + i));
        check(afull === 1'b0, "R6", "afull below 16 at depth 4096", 36'(afull), 36'h0);
        do_write(pat(515));
        check(afull === 1'b1, "R6", "afull at 16 at depth 4096", 36'(afull), 36'h1);
        settle();
        check(aempty === 1'b1, "R7", "aempty at 16 at depth 4096", 36'(aempty), 36'h1);
        do_write(pat(516));
        settle();
        check(aempty === 1'b0, "R7", "aempty clear at 17 at depth 4096", 36'(aempty), 36'h0);

        // R9: normal read timing and hold
        cur_req = "R9";
        do_read();
        repeat (3) @(negedge rclk);
        check(rd_data === last_rd, "R9", "rd_data holds without reads", rd_data, last_rd);

        // R10: pipelined mode
        af_level = 8'd200;
        ae_level = 8'd0;
        do_clear(3'd3, 1'b1);
        for (int i = 0; i < 3; i++) do_write(pat(600 + i));
        settle();
        for (int i = 0; i < 3; i++) do_read();
        check(empty === 1'b1, "R10", "empty after last pipelined read", 36'(empty), 36'h1);

        // R11: code 6 acts as 36x128
        cur_req = "R11";
        do_clear(3'd6, 1'b0);
        for (int i = 0; i < 127; i++) do_write(36'hF_0000_0000 | 36'(i));
        check(full === 1'b0, "R11", "code 6 not full at 127", 36'(full), 36'h0);
        do_write(36'hF_FFFF_FFFF);
        check(full === 1'b1, "R11", "code 6 full at 128", 36'(full), 36'h1);
        settle();
        do_read();
        check(rd_data === 36'hF_0000_0000, "R11", "code 6 keeps 36 bits", rd_data, 36'hF_0000_0000);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule